// File: doc/BRIEF.md
# Channel-Select Control with Interrupt Merge

This block is the control and status core of a four-way downstream bus switch. A host writes a single control byte through a plain strobe port. A three-bit field in that byte either disconnects every channel or names exactly one channel to connect. The block turns the field into four one-hot channel-enable outputs that drive the switch fabric.

Each downstream channel also has an active-low interrupt line. The block passes all four lines through a synchronizer. It merges them into one active-low interrupt output, which asserts no matter which channel is connected. On a read strobe it captures the synchronized interrupt levels into the upper nibble of the returned byte. The lower nibble holds the stored control bits. The host reads the byte to find which channels are requesting service, selects one of them, and clears the request at its source. The indication follows the input level and needs no clearing write.

Top module: `chsel_irq_ctrl`

## Requirements
- R1: After reset, ch_en is 4'b0000, irq_out_n is 1 and rd_data is 8'h00. A read with all interrupt inputs high returns 8'h00.
- R2: When a written byte has bit 2 equal to 0, ch_en is 4'b0000 after the write, whatever bits 1:0 hold.
- R3: When a written byte has bit 2 equal to 1, bits 1:0 select one channel after the write: 00 sets ch_en to 4'b0001, 01 to 4'b0010, 10 to 4'b0100 and 11 to 4'b1000.
- R4: ch_en changes only on the clock edge that accepts a write, takes the new value right after that edge, and never has more than one bit high.
- R5: A read strobe loads rd_data at its clock edge with bits 3:0 equal to the stored control bits 3:0. The new value is visible right after that edge.
- R6: Read bit 4+i is 1 exactly when interrupt input i was low as seen through the 2-stage synchronizer at the read edge. Any combination of the four bits may be 1 at once.
- R7: Bits 7:4 of a written byte are discarded. Bit 3 is stored and read back, but has no effect on ch_en.
- R8: irq_out_n goes low two clock edges after any interrupt input goes low, whether or not that channel is selected.
- R9: irq_out_n returns high two clock edges after the last low interrupt input goes high. Its status bit then reads 0, with no write in between.
- R10: Without a read strobe, rd_data holds its last captured value even when the interrupt inputs change.
- R11: When a read and a write share a clock edge, the read returns the control bits stored before that write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | 8 | Control byte to write |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rd_data | output | 8 | Captured byte: interrupt status in 7:4, control bits in 3:0 |
| irq_in_n | input | 4 | Active-low interrupt input per channel |
| ch_en | output | 4 | One-hot channel enables |
| irq_out_n | output | 1 | Merged active-low interrupt output |

## Verification
A corrupted control register shows on ch_en right after the edge that stored it, as a missing, wrong or doubled enable. It also shows in the low nibble of the next read. A fault in the synchronizer or the merge shows as irq_out_n moving one edge too early or too late, or not following a channel that is not selected. A wrong read capture shows as a status nibble that mixes up channel order, or as rd_data that drifts between reads. Every check samples on the falling edge right after the edge where the change is due, so an error of one cycle in timing is caught.

// File: rtl/chsel_irq_pkg.sv
package chsel_irq_pkg;
    // Control field layout inside the written byte
    localparam int CTL_W     = 4;   // stored control bits
    localparam int SEL_LSB   = 0;   // channel index field starts here
    localparam int EN_BIT    = 2;   // connect enable
    localparam int SPARE_BIT = 3;   // stored, no function
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_n_i,
    output logic [W-1:0] sync_n_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.stg[0] = async_n_i;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.stg[s] = sync_q.stg[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;   // inactive level for active-low lines
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_n_o = sync_q.stg[STAGES-1];
endmodule

// File: rtl/chsel_decode.sv
module chsel_decode #(
    parameter int N_CH  = 4,
    parameter int SEL_W = $clog2(N_CH)
) (
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [N_CH-1:0]  onehot_o
);
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign onehot_o[c] = en_i && (sel_i == SEL_W'(c));
    end
endmodule

// File: rtl/chsel_irq_merge.sv
module chsel_irq_merge #(
    parameter int N_CH = 4
) (
    input  logic [N_CH-1:0] irq_sync_n_i,
    output logic [N_CH-1:0] status_o,
    output logic            irq_n_o
);
    assign status_o = ~irq_sync_n_i;
    assign irq_n_o  = ~(|status_o);
endmodule

// File: rtl/chsel_irq_ctrl.sv
module chsel_irq_ctrl
    import chsel_irq_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CTL_W+N_CH-1:0]   wr_data,
    input  logic                    rd_en,
    output logic [CTL_W+N_CH-1:0]   rd_data,
    input  logic [N_CH-1:0]         irq_in_n,
    output logic [N_CH-1:0]         ch_en,
    output logic                    irq_out_n
);
    localparam int DATA_W = CTL_W + N_CH;
    localparam int SEL_W  = $clog2(N_CH);

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [DATA_W-1:0] rd;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [N_CH-1:0] irq_sync_n;
    logic [N_CH-1:0] irq_status;

    chsel_sync #(
        .W      (N_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_n_i (irq_in_n),
        .sync_n_o  (irq_sync_n)
    );

    chsel_irq_merge #(
        .N_CH (N_CH)
    ) u_merge (
        .irq_sync_n_i (irq_sync_n),
        .status_o     (irq_status),
        .irq_n_o      (irq_out_n)
    );

    chsel_decode #(
        .N_CH  (N_CH),
        .SEL_W (SEL_W)
    ) u_dec (
        .en_i     (st_q.ctl[EN_BIT]),
        .sel_i    (st_q.ctl[SEL_LSB +: SEL_W]),
        .onehot_o (ch_en)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctl = wr_data[CTL_W-1:0];     // upper bits discarded
        end
        if (rd_en) begin
            st_d.rd = {irq_status, st_q.ctl};  // pre-write control bits
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd;
endmodule

// File: rtl/chsel_irq_ctrl_chk.sv
module chsel_irq_ctrl_chk
    import chsel_irq_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [CTL_W+N_CH-1:0] wr_data,
    input logic                  rd_en,
    input logic [CTL_W+N_CH-1:0] rd_data,
    input logic [N_CH-1:0]       irq_in_n,
    input logic [N_CH-1:0]       ch_en,
    input logic                  irq_out_n
);
    localparam int SEL_W = $clog2(N_CH);

    // edges seen since reset, saturating
    logic [3:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 4'hF) begin
            age_q <= age_q + 4'd1;
        end
    end

    // R4: never two enables at once
    a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_en));

    // R4: enables move only on a write
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ch_en));

    // R2: cleared enable bit disconnects all
    a_r2_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[EN_BIT]) |=> (ch_en == '0));

    // R3: set enable bit picks the indexed channel
    a_r3_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[EN_BIT]) |=>
        (ch_en == (N_CH'(1) << $past(wr_data[SEL_LSB +: SEL_W]))));

    // R10: read byte holds without a strobe
    a_r10_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R8: merged output follows inputs after the synchronizer delay
    a_r8_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 4'(SYNC_STAGES)) |->
        (irq_out_n == (&$past(irq_in_n, SYNC_STAGES))));

    // R6: captured status equals inverted synchronized inputs
    a_r6_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && age_q >= 4'(SYNC_STAGES)) |=>
        (rd_data[CTL_W +: N_CH] == ~$past(irq_in_n, SYNC_STAGES + 1)));
endmodule

bind chsel_irq_ctrl chsel_irq_ctrl_chk #(
    .N_CH        (N_CH),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .irq_in_n  (irq_in_n),
    .ch_en     (ch_en),
    .irq_out_n (irq_out_n)
);

// File: tb/chsel_irq_ctrl_test.sv
`timescale 1ns/1ps
module chsel_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] irq_in_n = 4'hF;
    logic [3:0] ch_en;
    logic       irq_out_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb[$];

    logic [3:0] ctl_model = 4'h0;

    always #2 clk = ~clk;   // 250 MHz

    chsel_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .irq_in_n  (irq_in_n),
        .ch_en     (ch_en),
        .irq_out_n (irq_out_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_en(input logic [3:0] c);
        return c[2] ? (4'b0001 << c[1:0]) : 4'b0000;
    endfunction

    task automatic do_write(input logic [7:0] b, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        ctl_model = b[3:0];
        @(negedge clk);
        wr_en = 1'b0;
        chk(tag, {4'h0, ch_en}, {4'h0, exp_en(ctl_model)});
    endtask

    task automatic do_read(input string tag);
        sb_item_t it;
        @(negedge clk);
        rd_en = 1'b1;
        it.exp = {~irq_in_n, ctl_model};
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_rw(input logic [7:0] b, input string tag);
        sb_item_t it;
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; wr_data = b;
        it.exp = {~irq_in_n, ctl_model};
        it.tag = tag;
        sb.push_back(it);
        ctl_model = b[3:0];
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk({tag, " enables"}, {4'h0, ch_en}, {4'h0, exp_en(ctl_model)});
    endtask

    task automatic set_irq(input logic [3:0] v);
        @(negedge clk);
        irq_in_n = v;
        repeat (3) @(negedge clk);
    endtask

    // monitor: compare each read result against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5: unexpected read, actual %02h expected none", rd_data);
                end else begin
                    sb_item_t it;
                    it = sb.pop_front();
                    chk(it.tag, rd_data, it.exp);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ch_en", {4'h0, ch_en}, 8'h00);
        chk("R1 irq_out_n", {7'h0, irq_out_n}, 8'h01);
        chk("R1 rd_data", rd_data, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        do_read("R1 read after reset");

        // R2 disabled select field
        do_write(8'h03, "R2 en=0 sel=3");
        do_write(8'h01, "R2 en=0 sel=1");
        do_read("R5 low nibble 01");

        // R3 each channel
        for (int c = 0; c < 4; c++) begin
            do_write(8'h04 | 8'(c), "R3 select");
            do_read("R5 low nibble select");
        end

        // R4 enables stay put without a write
        repeat (4) @(negedge clk);
        chk("R4 hold", {4'h0, ch_en}, 8'h08);

        // R7 upper bits ignored, bit 3 kept
        do_write(8'hFD, "R7 upper bits ignored");
        do_read("R7 readback 0D");
        do_write(8'h0E, "R7 spare bit no effect");
        do_read("R7 readback 0E");
        do_write(8'h00, "R2 disconnect");

        // R8 latency on an unselected channel
        @(negedge clk);
        irq_in_n = 4'b1011;
        @(negedge clk);
        chk("R8 after one edge", {7'h0, irq_out_n}, 8'h01);
        @(negedge clk);
        chk("R8 after two edges", {7'h0, irq_out_n}, 8'h00);
        do_read("R6 channel 2 status");

        // R6 multiple channels
        do_write(8'h05, "R3 select ch1");
        set_irq(4'b0110);
        chk("R8 multi", {7'h0, irq_out_n}, 8'h00);
        do_read("R6 channels 0 and 3");

        // R9 self clear
        @(negedge clk);
        irq_in_n = 4'hF;
        @(negedge clk);
        chk("R9 after one edge", {7'h0, irq_out_n}, 8'h00);
        @(negedge clk);
        chk("R9 after two edges", {7'h0, irq_out_n}, 8'h01);
        do_read("R9 status cleared");

        // R10 snapshot holds
        set_irq(4'b1101);
        do_read("R10 capture ch1");
        @(negedge clk);
        held = rd_data;
        set_irq(4'hF);
        repeat (4) @(negedge clk);
        chk("R10 hold after input change", rd_data, held);
        chk("R10 hold value", rd_data, 8'h25);

        // R11 read and write together
        set_irq(4'b0000);
        do_rw(8'h07, "R11 read sees old control");
        do_read("R6 all four, R11 new control");
        set_irq(4'hF);

        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R5: pending reads actual %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule